// File: doc/BRIEF.md
# Mode-dependent GPIO address port

This block manages two 8-bit general-purpose I/O ports, called port A and port B, whose pins can be taken over to carry a 16-bit external address. Port A carries the upper byte and port B the lower byte. Each port has a data register and a direction register, all reached through a small register interface. Reads are combinational from the register offset. Writes take effect on the rising clock edge.

A 2-bit mode input sets who owns the pins and where data-register reads come from. In single-chip mode the pins are plain GPIO. Each pin drives its stored data bit when its direction bit is 1 and is an input otherwise. In expanded mode every pin is forced to output and carries an address bit. Emulation mode also hands the pins to the address. In addition, data-register reads return the external-bus read data, and data-register writes are passed on to the external bus as a write strobe with port select and data. Bit 0 of port B can carry an upper-data-strobe signal in place of address bit 0.

Top module: `addr_port_pair`

## Requirements
- R1: After reset, both data registers and both direction registers are 0, so every pin starts as an input.
- R2: In single-chip mode, a read at offset 0 (port A data) or offset 1 (port B data) returns, for each bit, the stored data bit where the direction bit is 1 and the pin input where it is 0. Port A is pin_in[15:8] and port B is pin_in[7:0].
- R3: In emulation mode, a read at offset 0 or 1 returns ext_rdata, whatever the direction bits hold.
- R4: A read at offset 2 (port A direction) or offset 3 (port B direction) returns the stored direction byte in every mode.
- R5: In emulation mode, a write strobe to offset 0 or 1 raises ext_wr in the same cycle. ext_wsel is 0 for port A and 1 for port B, and ext_wdata equals reg_wdata. In every other mode or offset, ext_wr stays 0.
- R6: In expanded and emulation modes, pin_oe is all ones and pin_out equals bus_addr: port A pins drive bits 15..8 and port B pins drive bits 7..0.
- R7: In single-chip mode, pin_oe equals {port A direction, port B direction} and pin_out equals {port A data, port B data}.
- R8: When strobe_en is 1 and the pins carry the address, pin_out[0] equals strobe_in instead of bus_addr[0]. In single-chip mode strobe_en has no effect.
- R9: Data registers can be written while the pins carry the address. The stored value is not driven, and it is returned once the block goes back to single-chip mode.
- R10: Mode encoding: 00 is single-chip, 01 is expanded, 10 is emulation, and 11 behaves exactly like single-chip.
- R11: A register changes only on a rising clock edge with reg_wr at 1. Without reg_wr, a value on reg_wdata leaves the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode (R10) |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| pin_in | input | 16 | Buffered pin inputs, port A high byte |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| bus_addr | input | 16 | External address to place on the pins |
| strobe_en | input | 1 | Enables the upper-data-strobe on port B bit 0 |
| strobe_in | input | 1 | Upper-data-strobe value |
| ext_rdata | input | 8 | Read data captured from the external bus |
| ext_wr | output | 1 | Forwarded write strobe to the external bus |
| ext_wsel | output | 1 | Forwarded port select, 0 for A and 1 for B |
| ext_wdata | output | 8 | Forwarded write data |

## Verification
The bench sweeps all four mode codes, each with arithmetic patterns of data, direction, pin and bus values. It checks the per-bit merge of data and pin input on GPIO reads; a design that swapped the merge polarity or ignored direction would return the wrong bits in the mixed patterns. It checks that mode 11 acts as single-chip and that port B bit 0 switches to the strobe only while the pins carry the address; a wrong decode would drive addresses or a stray strobe in GPIO use. It also writes data registers while the pins are owned by the address and reads them back later, and confirms that forwarding happens only in emulation and only for data offsets. A design that lost those writes, or forwarded direction writes, would miscompare there.

// File: rtl/addr_port_pkg.sv
package addr_port_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE    = 2'b00,
        MODE_EXPANDED  = 2'b01,
        MODE_EMULATION = 2'b10,
        MODE_ALT_CHIP  = 2'b11
    } run_mode_e;

    localparam int NUM_PORTS = 2;
    localparam int REG_AW    = 2;

    function automatic logic addr_owns_pins(input run_mode_e m);
        return (m == MODE_EXPANDED) || (m == MODE_EMULATION);
    endfunction

    function automatic logic is_emul(input run_mode_e m);
        return m == MODE_EMULATION;
    endfunction
endpackage

// File: rtl/port_reg_bank.sv
module port_reg_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dat,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dat_q,
    output logic [W-1:0] dir_q
);
    typedef struct packed {
        logic [W-1:0] dat;
        logic [W-1:0] dir;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_dat) bank_d.dat = wdata;
        if (wr_dir) bank_d.dir = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign dat_q = bank_q.dat;
    assign dir_q = bank_q.dir;
endmodule

// File: rtl/port_pin_drive.sv
module port_pin_drive #(
    parameter int W          = 8,
    parameter bit HAS_STROBE = 1'b0
) (
    input  logic         addr_owned,
    input  logic [W-1:0] addr_bits,
    input  logic [W-1:0] dat,
    input  logic [W-1:0] dir,
    input  logic         strobe_en,
    input  logic         strobe_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    logic [W-1:0] bus_val;

    generate
        if (HAS_STROBE) begin : g_strobe
            always_comb begin
                bus_val = addr_bits;
                if (strobe_en) bus_val[0] = strobe_in;
            end
        end else begin : g_plain
            logic unused_strobe;
            assign unused_strobe = strobe_en ^ strobe_in;
            assign bus_val = addr_bits;
        end
    endgenerate

    always_comb begin
        if (addr_owned) begin
            pin_out = bus_val;
            pin_oe  = '1;
        end else begin
            pin_out = dat;
            pin_oe  = dir;
        end
    end
endmodule

// File: rtl/port_read_sel.sv
module port_read_sel
    import addr_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic                        emul,
    input  logic [NUM_PORTS-1:0][W-1:0] dat,
    input  logic [NUM_PORTS-1:0][W-1:0] dir,
    input  logic [NUM_PORTS-1:0][W-1:0] pin,
    input  logic [W-1:0]                ext_rdata,
    output logic [W-1:0]                rdata
);
    logic         sel;
    logic [W-1:0] gpio_view;

    assign sel       = reg_addr[0];
    assign gpio_view = (dat[sel] & dir[sel]) | (pin[sel] & ~dir[sel]);

    always_comb begin
        if (reg_addr[1])  rdata = dir[sel];
        else if (emul)    rdata = ext_rdata;
        else              rdata = gpio_view;
    end
endmodule

// File: rtl/ext_write_fwd.sv
module ext_write_fwd
    import addr_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              emul,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic              ext_wr,
    output logic              ext_wsel,
    output logic [W-1:0]      ext_wdata
);
    assign ext_wr    = emul & reg_wr & ~reg_addr[1];
    assign ext_wsel  = reg_addr[0];
    assign ext_wdata = reg_wdata;
endmodule

// File: rtl/addr_port_pair.sv
module addr_port_pair
    import addr_port_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int BUS_W = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    input  logic [BUS_W-1:0]  pin_in,
    output logic [BUS_W-1:0]  pin_out,
    output logic [BUS_W-1:0]  pin_oe,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic              strobe_en,
    input  logic              strobe_in,
    input  logic [PORT_W-1:0] ext_rdata,
    output logic              ext_wr,
    output logic              ext_wsel,
    output logic [PORT_W-1:0] ext_wdata
);
    run_mode_e mode_e;
    logic      owned;
    logic      emul;

    assign mode_e = run_mode_e'(mode);
    assign owned  = addr_owns_pins(mode_e);
    assign emul   = is_emul(mode_e);

    // index 0 is port A (upper byte), index 1 is port B (lower byte)
    logic [NUM_PORTS-1:0][PORT_W-1:0] dat_q;
    logic [NUM_PORTS-1:0][PORT_W-1:0] dir_q;
    logic [NUM_PORTS-1:0][PORT_W-1:0] pin_port;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int LSB = (NUM_PORTS - 1 - p) * PORT_W;
        logic wr_dat, wr_dir;

        assign wr_dat      = reg_wr && (reg_addr == REG_AW'(p));
        assign wr_dir      = reg_wr && (reg_addr == REG_AW'(NUM_PORTS + p));
        assign pin_port[p] = pin_in[LSB +: PORT_W];

        port_reg_bank #(.W(PORT_W)) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_dat(wr_dat),
            .wr_dir(wr_dir),
            .wdata (reg_wdata),
            .dat_q (dat_q[p]),
            .dir_q (dir_q[p])
        );

        port_pin_drive #(.W(PORT_W), .HAS_STROBE(p == NUM_PORTS - 1)) drv_i (
            .addr_owned(owned),
            .addr_bits (bus_addr[LSB +: PORT_W]),
            .dat       (dat_q[p]),
            .dir       (dir_q[p]),
            .strobe_en (strobe_en),
            .strobe_in (strobe_in),
            .pin_out   (pin_out[LSB +: PORT_W]),
            .pin_oe    (pin_oe[LSB +: PORT_W])
        );
    end

    port_read_sel #(.W(PORT_W)) rd_i (
        .reg_addr (reg_addr),
        .emul     (emul),
        .dat      (dat_q),
        .dir      (dir_q),
        .pin      (pin_port),
        .ext_rdata(ext_rdata),
        .rdata    (reg_rdata)
    );

    ext_write_fwd #(.W(PORT_W)) fwd_i (
        .emul     (emul),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .ext_wr   (ext_wr),
        .ext_wsel (ext_wsel),
        .ext_wdata(ext_wdata)
    );
endmodule

// File: rtl/addr_port_pair_chk.sv
module addr_port_pair_chk #(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic [W-1:0]      reg_wdata,
    input logic [W-1:0]      reg_rdata,
    input logic [W-1:0]      ext_rdata,
    input logic              ext_wr,
    input logic [2*W-1:0]    pin_oe,
    input logic [1:0][W-1:0] dat_q,
    input logic [1:0][W-1:0] dir_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (dat_q == '0 && dir_q == '0));

    a_r3_emul_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !reg_addr[1]) |-> reg_rdata == ext_rdata);

    a_r5_fwd_only_emul: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |-> (mode == 2'b10 && reg_wr && !reg_addr[1]));

    a_r6_addr_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 || mode == 2'b10) |-> (&pin_oe));

    a_r7_gpio_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b11) |-> pin_oe == {dir_q[0], dir_q[1]});

    a_r11_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=> dir_q[0] == $past(reg_wdata));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(dat_q) && $stable(dir_q)));
endmodule

bind addr_port_pair addr_port_pair_chk #(.W(PORT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ext_rdata(ext_rdata),
    .ext_wr   (ext_wr),
    .pin_oe   (pin_oe),
    .dat_q    (dat_q),
    .dir_q    (dir_q)
);

// File: tb/addr_port_pair_tb_top.sv
module addr_port_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic [15:0] bus_addr = '0;
    logic        strobe_en = 1'b0;
    logic        strobe_in = 1'b0;
    logic [7:0]  ext_rdata = '0;
    logic        ext_wr, ext_wsel;
    logic [7:0]  ext_wdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] sdat [2];
    logic [7:0] sdir [2];

    always #5 clk = ~clk;

    addr_port_pair dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .bus_addr(bus_addr), .strobe_en(strobe_en), .strobe_in(strobe_in),
        .ext_rdata(ext_rdata), .ext_wr(ext_wr), .ext_wsel(ext_wsel),
        .ext_wdata(ext_wdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int off);
        logic [7:0] pv;
        if (off >= 2) return sdir[off-2];
        if (mode == 2'b10) return ext_rdata;
        pv = (off == 0) ? pin_in[15:8] : pin_in[7:0];
        return (sdat[off] & sdir[off]) | (pv & ~sdir[off]);
    endfunction

    // drives a write at a falling edge, checks forwarding, commits at rising edge
    task automatic wr(input int off, input logic [7:0] d);
        @(negedge clk);
        reg_addr = 2'(off); reg_wdata = d; reg_wr = 1'b1;
        #1;
        chk("R5 ext_wr", {15'd0, ext_wr}, {15'd0, (mode == 2'b10) && off < 2});
        if (mode == 2'b10 && off < 2) begin
            chk("R5 ext_wsel", {15'd0, ext_wsel}, 16'(off & 1));
            chk("R5 ext_wdata", {8'd0, ext_wdata}, {8'd0, d});
        end
        @(posedge clk);
        #1 reg_wr = 1'b0;
        if (off < 2) sdat[off] = d; else sdir[off-2] = d;
    endtask

    task automatic check_reads(input string tag);
        for (int off = 0; off < 4; off++) begin
            reg_addr = 2'(off);
            #1;
            chk(tag, {8'd0, reg_rdata}, {8'd0, exp_rd(off)});
        end
    endtask

    task automatic check_pins();
        logic [15:0] eo, ee;
        if (mode == 2'b01 || mode == 2'b10) begin
            eo = bus_addr;
            if (strobe_en) eo[0] = strobe_in;
            ee = 16'hFFFF;
            chk(strobe_en ? "R8 strobe pin_out" : "R6 pin_out", pin_out, eo);
            chk("R6 pin_oe", pin_oe, ee);
        end else begin
            chk("R7 pin_out (R8 strobe ignored, R10 mode)", pin_out, {sdat[0], sdat[1]});
            chk("R7 pin_oe", pin_oe, {sdir[0], sdir[1]});
        end
    endtask

    initial begin
        fork
            begin
                #(200000 * 10);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=finished");
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        join_none

        sdat[0] = '0; sdat[1] = '0; sdir[0] = '0; sdir[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: directions clear, so data reads show pins
        pin_in = 16'hA55A;
        #1;
        check_reads("R1 reset reads");
        chk("R1 reset pin_oe", pin_oe, 16'h0000);
        wr(2, 8'hFF); wr(3, 8'hFF);
        reg_addr = 2'd0; #1;
        chk("R1 port A data reset", {8'd0, reg_rdata}, 16'h0000);
        reg_addr = 2'd1; #1;
        chk("R1 port B data reset", {8'd0, reg_rdata}, 16'h0000);

        // main sweep: every mode code, arithmetic patterns
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                mode      = 2'(m);
                strobe_en = i[0];
                wr(0, 8'(i * 91 + 3));
                wr(1, 8'(i * 53 ^ 8'hC6));
                wr(2, 8'(i * 37 ^ 8'h5A));
                wr(3, 8'(i * 71 + 17));
                @(negedge clk);
                pin_in    = 16'(i * 16'h3B29 ^ 16'h9D4E);
                bus_addr  = 16'(i * 16'h1357 + 16'h0246);
                ext_rdata = 8'(i * 29 + 101);
                strobe_in = ~bus_addr[0];
                #1;
                check_reads(m == 2 ? "R3/R4 emulation reads" :
                            (m == 1 ? "R2/R4 expanded reads" : "R2/R4 GPIO reads (R10)"));
                check_pins();
                // R11: strobe low leaves registers alone
                reg_addr = 2'd2; reg_wdata = ~sdir[0];
                @(posedge clk); #1;
                chk("R5 no forward without strobe", {15'd0, ext_wr}, 16'd0);
                @(negedge clk); #1;
                chk("R11 no write without strobe", {8'd0, reg_rdata}, {8'd0, sdir[0]});
            end
        end

        // R9: write data while address owns pins, then return to GPIO
        @(negedge clk);
        mode = 2'b01; strobe_en = 1'b0; bus_addr = 16'h7E81;
        wr(0, 8'h3C); wr(1, 8'hC3);
        #1;
        chk("R9 address still driven", pin_out, 16'h7E81);
        @(negedge clk);
        mode = 2'b00;
        wr(2, 8'hFF); wr(3, 8'hFF);
        reg_addr = 2'd0; #1;
        chk("R9 port A data kept", {8'd0, reg_rdata}, 16'h003C);
        reg_addr = 2'd1; #1;
        chk("R9 port B data kept", {8'd0, reg_rdata}, 16'h00C3);
        chk("R9 data driven in GPIO", pin_out, 16'h3CC3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule